// File: doc/BRIEF.md
# Max-log-MAP soft-in soft-out decoder (one half-iteration)

This block runs one half-iteration of an iterative parallel-concatenated decoder for a rate-1/2 recursive systematic code with 4 memory cells (16 trellis states). Its feedback taps are all ones (1+D+D^2+D^3+D^4) and its parity taps are 1+D^4. A block of N positions is first written into three internal RAMs through a simple write port. Each position holds a soft systematic value, a soft parity value and an a priori log-likelihood ratio. On the first half-iteration the a priori value is zero everywhere.

After `start`, the block sweeps the trellis backwards and keeps every backward state-metric vector. It then sweeps forwards, holding only the current forward vector. For each position it emits one extrinsic value and one hard decision, in index order, once the forward metrics of that position are known. Every recursion step takes the plain maximum of the competing branch sums, with no logarithmic correction, and then subtracts the largest of the 16 results so the metrics stay bounded. A one-cycle `done` pulse closes the block. Interleaving and iteration control are left to the surrounding logic.

Top module: `mlm_siso`

## Requirements
- R1: The trellis state is s[3:0], where s[i] is the feedback register value i+1 steps back. Input u gives a = u XOR s[0] XOR s[1] XOR s[2] XOR s[3], next state {s[2:0], a} and parity v = a XOR s[3]. With U = +1 for u=1 and -1 for u=0, and V defined the same way from v, the branch metric is floor((U·(La+x) + V·y)/2). So each position has only four branch-metric values.
- R2: The backward recursion starts after the last position with metric 0 for state 0 and NEG = -2^(MW-2) for every other state (-1024 at default parameters).
- R3: The forward recursion starts before position 0 with metric 0 for state 0 and NEG for every other state.
- R4: Each backward and forward step takes the maximum over the two competing branch sums of each state, then subtracts the largest of the 16 results. The stored vector therefore has maximum exactly 0.
- R5: The extrinsic value of position k is (max over u=1 transitions − max over u=0 transitions of alpha+gamma+beta) − La − x. It is saturated symmetrically to ±(2^(EW-1)−1).
- R6: hard_bit is 1 when the total LLR (max over u=1 − max over u=0) is strictly positive, and 0 otherwise.
- R7: Outputs for positions 0..N−1 appear in index order on consecutive cycles. Position k is valid N+1+k cycles after the clock edge that samples `start`.
- R8: `done` is high for exactly one cycle, the cycle after the last extrinsic value (2N+1 cycles after the start edge).
- R9: A `start` pulse while a block is being decoded is ignored. The output sequence, its timing and the single `done` pulse are unchanged.
- R10: After reset, ext_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one position into the input RAMs |
| wr_addr | input | AW | Position index to write |
| wr_sys | input | W | Signed soft systematic value |
| wr_par | input | W | Signed soft parity value |
| wr_apri | input | W | Signed a priori LLR |
| start | input | 1 | Begin decoding the stored block (sampled only when idle) |
| ext_valid | output | 1 | ext_idx, ext_val and hard_bit are valid |
| ext_idx | output | AW | Position of the current output |
| ext_val | output | EW | Saturated signed extrinsic LLR |
| hard_bit | output | 1 | Hard decision for the position |
| done | output | 1 | One-cycle pulse after the last output |

## Verification
Three kinds of internal fault show up differently at the ports:
- A wrong stored backward vector, or a bad backward start value, corrupts the extrinsic value of the position that uses it. It appears no earlier than N+1 cycles after start, because every output waits for the full backward sweep.
- A fault in the forward vector propagates from the position where it occurs to every later position in the same block.
- A missing or wrong renormalisation shows only as a drift in extrinsic values over a long block, not at once.

For these reasons the bench compares every extrinsic value and hard decision of several complete blocks against an arithmetic model, and checks the cycle of every output.

// File: rtl/mlm_pkg.sv
package mlm_pkg;

   // memory cells of the constituent code and the number of trellis states
   localparam int SW = 4;
   localparam int NS = 1 << SW;

   typedef enum logic [1:0] {ST_IDLE, ST_BWD, ST_FWD, ST_DONE} phase_t;

   // recursive feedback: every register cell feeds back
   function automatic logic fb_bit(input logic [SW-1:0] s, input logic u);
      return u ^ (^s);
   endfunction

   function automatic logic [SW-1:0] nxt_state(input logic [SW-1:0] s, input logic u);
      return {s[SW-2:0], fb_bit(s, u)};
   endfunction

   // parity taps: current feedback value and the oldest cell
   function automatic logic par_bit(input logic [SW-1:0] s, input logic u);
      return fb_bit(s, u) ^ s[SW-1];
   endfunction

endpackage

// File: rtl/mlm_branch.sv
module mlm_branch #(
   parameter int W  = 6,
   parameter int GW = W + 2
) (
   input  logic signed [W-1:0] x,
   input  logic signed [W-1:0] y,
   input  logic signed [W-1:0] la,
   output logic [3:0][GW-1:0]  gam
);
   logic signed [GW-1:0] sxl, sy;

   assign sxl = GW'(x) + GW'(la);
   assign sy  = GW'(y);

   // index {u,v}; bit value 1 maps to +1, 0 to -1
   for (genvar i = 0; i < 4; i++) begin : g_gam
      logic signed [GW-1:0] sum;
      assign sum    = (i[1] ? sxl : -sxl) + (i[0] ? sy : -sy);
      assign gam[i] = sum >>> 1;
   end
endmodule

// File: rtl/mlm_acs.sv
module mlm_acs
   import mlm_pkg::*;
#(
   parameter int MW  = 12,
   parameter int GW  = 8,
   parameter bit FWD = 1'b1
) (
   input  logic [NS-1:0][MW-1:0] m_in,
   input  logic [3:0][GW-1:0]    gam,
   output logic [NS-1:0][MW-1:0] m_out
);
   localparam int RW = MW + 1;

   logic signed [RW-1:0] raw [NS];
   logic signed [RW-1:0] m_top;

   if (FWD) begin : g_fwd
      always_comb begin
         logic [SW-1:0]        ns;
         logic                 v;
         logic signed [RW-1:0] cand;
         for (int s = 0; s < NS; s++) raw[s] = {1'b1, {MW{1'b0}}};
         for (int s = 0; s < NS; s++) begin
            for (int u = 0; u < 2; u++) begin
               ns   = nxt_state(SW'(s), u[0]);
               v    = par_bit(SW'(s), u[0]);
               cand = RW'($signed(m_in[s])) + RW'($signed(gam[{u[0], v}]));
               if (cand > raw[ns]) raw[ns] = cand;
            end
         end
      end
   end else begin : g_bwd
      always_comb begin
         logic [SW-1:0]        ns;
         logic                 v;
         logic signed [RW-1:0] cand, best;
         for (int s = 0; s < NS; s++) begin
            best = {1'b1, {MW{1'b0}}};
            for (int u = 0; u < 2; u++) begin
               ns   = nxt_state(SW'(s), u[0]);
               v    = par_bit(SW'(s), u[0]);
               cand = RW'($signed(m_in[ns])) + RW'($signed(gam[{u[0], v}]));
               if (cand > best) best = cand;
            end
            raw[s] = best;
         end
      end
   end

   // renormalise: the largest metric becomes zero
   always_comb begin
      m_top = raw[0];
      for (int s = 1; s < NS; s++) if (raw[s] > m_top) m_top = raw[s];
      for (int s = 0; s < NS; s++) m_out[s] = MW'(raw[s] - m_top);
   end
endmodule

// File: rtl/mlm_llr.sv
module mlm_llr
   import mlm_pkg::*;
#(
   parameter int MW = 12,
   parameter int GW = 8
) (
   input  logic [NS-1:0][MW-1:0] alpha,
   input  logic [NS-1:0][MW-1:0] beta,
   input  logic [3:0][GW-1:0]    gam,
   output logic signed [MW+2:0]  delta
);
   localparam int LW = MW + 2;

   always_comb begin
      logic [SW-1:0]        ns;
      logic                 v;
      logic signed [LW-1:0] sum, best1, best0;
      best1 = {1'b1, {(LW-1){1'b0}}};
      best0 = {1'b1, {(LW-1){1'b0}}};
      for (int s = 0; s < NS; s++) begin
         for (int u = 0; u < 2; u++) begin
            ns  = nxt_state(SW'(s), u[0]);
            v   = par_bit(SW'(s), u[0]);
            sum = LW'($signed(alpha[s])) + LW'($signed(gam[{u[0], v}]))
                + LW'($signed(beta[ns]));
            if (u[0]) begin
               if (sum > best1) best1 = sum;
            end else if (sum > best0) begin
               best0 = sum;
            end
         end
      end
      delta = (LW+1)'(best1) - (LW+1)'(best0);
   end
endmodule

// File: rtl/mlm_siso.sv
module mlm_siso
   import mlm_pkg::*;
#(
   parameter int N  = 16,
   parameter int W  = 6,
   parameter int MW = 12,
   parameter int EW = 8,
   parameter int AW = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic signed [W-1:0]  wr_sys,
   input  logic signed [W-1:0]  wr_par,
   input  logic signed [W-1:0]  wr_apri,
   input  logic                 start,
   output logic                 ext_valid,
   output logic [AW-1:0]        ext_idx,
   output logic signed [EW-1:0] ext_val,
   output logic                 hard_bit,
   output logic                 done
);
   localparam int GW    = W + 2;
   localparam int DW    = MW + 3;
   localparam int XW    = DW + 1;
   localparam int NEGI  = -(1 << (MW - 2));
   localparam int EMAXI = (1 << (EW - 1)) - 1;

   if (N < 2) begin : g_bad_n
      $error("mlm_siso: N must be at least 2");
   end
   if (MW < W + 6) begin : g_bad_mw
      $error("mlm_siso: MW too narrow for the soft input width");
   end
   if (EW > DW) begin : g_bad_ew
      $error("mlm_siso: EW wider than the LLR difference");
   end

   function automatic logic [NS-1:0][MW-1:0] init_vec();
      logic [NS-1:0][MW-1:0] r;
      for (int s = 0; s < NS; s++) r[s] = (s == 0) ? '0 : MW'(NEGI);
      return r;
   endfunction

   logic signed [W-1:0]   sys_m [N];
   logic signed [W-1:0]   par_m [N];
   logic signed [W-1:0]   apr_m [N];
   logic [NS-1:0][MW-1:0] bmem  [N];

   phase_t                phase;
   logic [AW-1:0]         cnt;
   logic [NS-1:0][MW-1:0] beta_q, beta_nx, alpha_q, alpha_nx;
   logic [3:0][GW-1:0]    gam;
   logic signed [W-1:0]   x, y, la;
   logic signed [DW-1:0]  delta;
   logic signed [XW-1:0]  e_full;
   logic signed [EW-1:0]  e_sat;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         sys_m[wr_addr] <= wr_sys;
         par_m[wr_addr] <= wr_par;
         apr_m[wr_addr] <= wr_apri;
      end
      if (phase == ST_BWD) bmem[cnt] <= beta_q;
   end

   assign x  = sys_m[cnt];
   assign y  = par_m[cnt];
   assign la = apr_m[cnt];

   mlm_branch #(.W(W), .GW(GW)) br_i (.x(x), .y(y), .la(la), .gam(gam));

   mlm_acs #(.MW(MW), .GW(GW), .FWD(1'b0)) acs_b_i (
      .m_in(beta_q), .gam(gam), .m_out(beta_nx));

   mlm_acs #(.MW(MW), .GW(GW), .FWD(1'b1)) acs_f_i (
      .m_in(alpha_q), .gam(gam), .m_out(alpha_nx));

   mlm_llr #(.MW(MW), .GW(GW)) llr_i (
      .alpha(alpha_q), .beta(bmem[cnt]), .gam(gam), .delta(delta));

   // extrinsic: remove a priori and systematic parts, then saturate
   assign e_full = XW'(delta) - XW'(la) - XW'(x);
   always_comb begin
      if (e_full > XW'(EMAXI))       e_sat = EW'(EMAXI);
      else if (e_full < XW'(-EMAXI)) e_sat = EW'(-EMAXI);
      else                           e_sat = EW'(e_full);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= ST_IDLE;
         cnt       <= '0;
         beta_q    <= init_vec();
         alpha_q   <= init_vec();
         ext_valid <= 1'b0;
         ext_idx   <= '0;
         ext_val   <= '0;
         hard_bit  <= 1'b0;
         done      <= 1'b0;
      end else begin
         ext_valid <= 1'b0;
         done      <= 1'b0;
         case (phase)
            ST_IDLE: if (start) begin
               phase  <= ST_BWD;
               cnt    <= AW'(N - 1);
               beta_q <= init_vec();
            end
            ST_BWD: begin
               beta_q <= beta_nx;
               if (cnt == '0) begin
                  phase   <= ST_FWD;
                  alpha_q <= init_vec();
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_FWD: begin
               alpha_q   <= alpha_nx;
               ext_valid <= 1'b1;
               ext_idx   <= cnt;
               ext_val   <= e_sat;
               hard_bit  <= (delta > 0);
               if (cnt == AW'(N - 1)) phase <= ST_DONE;
               else                   cnt   <= cnt + 1'b1;
            end
            default: begin
               done  <= 1'b1;
               phase <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/mlm_siso_chk.sv
module mlm_siso_chk
   import mlm_pkg::*;
#(
   parameter int N  = 16,
   parameter int MW = 12,
   parameter int EW = 8,
   parameter int AW = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input phase_t                phase,
   input logic [NS-1:0][MW-1:0] alpha_q,
   input logic [NS-1:0][MW-1:0] beta_q,
   input logic                  ext_valid,
   input logic [AW-1:0]         ext_idx,
   input logic [EW-1:0]         ext_val,
   input logic                  done
);
   localparam int NEGC = -(1 << (MW - 2));

   function automatic logic [NS-1:0][MW-1:0] start_vec();
      logic [NS-1:0][MW-1:0] r;
      for (int s = 0; s < NS; s++) r[s] = (s == 0) ? '0 : MW'(NEGC);
      return r;
   endfunction

   function automatic logic signed [MW-1:0] vmax(input logic [NS-1:0][MW-1:0] m);
      logic signed [MW-1:0] r;
      r = $signed(m[0]);
      for (int s = 1; s < NS; s++) if ($signed(m[s]) > r) r = $signed(m[s]);
      return r;
   endfunction

   p_bwd_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_BWD && $past(phase) == ST_IDLE) |-> beta_q == start_vec());

   p_fwd_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_FWD && $past(phase) == ST_BWD) |-> alpha_q == start_vec());

   p_bwd_norm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_BWD) |-> vmax(beta_q) == '0);

   p_fwd_norm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_FWD) |-> vmax(alpha_q) == '0);

   p_sym_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid |-> ext_val != {1'b1, {(EW-1){1'b0}}});

   p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && ext_idx != AW'(N - 1)) |=> (ext_valid && ext_idx == $past(ext_idx) + 1'b1));

   p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && ext_idx == AW'(N - 1)) |=> done);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind mlm_siso mlm_siso_chk #(.N(N), .MW(MW), .EW(EW), .AW(AW)) chk_i (
   .clk(clk), .rst_n(rst_n), .phase(phase), .alpha_q(alpha_q), .beta_q(beta_q),
   .ext_valid(ext_valid), .ext_idx(ext_idx), .ext_val(ext_val), .done(done));

// File: tb/mlm_siso_tb_top.sv
`timescale 1ns/1ps
module mlm_siso_tb_top;
   localparam int N   = 16;
   localparam int W   = 6;
   localparam int MW  = 12;
   localparam int EW  = 8;
   localparam int AW  = 4;
   localparam int NST = 16;
   localparam int NEG = -(1 << (MW - 2));
   localparam int SAT = (1 << (EW - 1)) - 1;
   // tap coefficients of D^1..D^4 (bit i is D^(i+1))
   localparam bit [3:0] FB_TAPS  = 4'b1111;
   localparam bit [3:0] PAR_TAPS = 4'b1000;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 wr_en = 1'b0;
   logic [AW-1:0]        wr_addr = '0;
   logic signed [W-1:0]  wr_sys = '0, wr_par = '0, wr_apri = '0;
   logic                 start = 1'b0;
   logic                 ext_valid, hard_bit, done;
   logic [AW-1:0]        ext_idx;
   logic signed [EW-1:0] ext_val;

   int nchk = 0, nfail = 0;
   bit finished = 1'b0;
   int tx [N], ty [N], tl [N];
   int exp_e [N], exp_h [N], ref_bit [N];
   bit use_ref = 1'b0;

   always #2 clk = ~clk;

   mlm_siso #(.N(N), .W(W), .MW(MW), .EW(EW), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_sys(wr_sys), .wr_par(wr_par), .wr_apri(wr_apri), .start(start),
      .ext_valid(ext_valid), .ext_idx(ext_idx), .ext_val(ext_val),
      .hard_bit(hard_bit), .done(done));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int fbk(input int s, input int u);
      int a = u;
      for (int i = 0; i < 4; i++) if (FB_TAPS[i]) a ^= (s >> i) & 1;
      return a;
   endfunction

   function automatic int nxt(input int s, input int u);
      return ((s << 1) | fbk(s, u)) & (NST - 1);
   endfunction

   function automatic int parity(input int s, input int u);
      int v = fbk(s, u);
      for (int i = 0; i < 4; i++) if (PAR_TAPS[i]) v ^= (s >> i) & 1;
      return v;
   endfunction

   // R1 branch metric
   function automatic int gm(input int la, input int x, input int y, input int u, input int v);
      int su = u ? 1 : -1;
      int sv = v ? 1 : -1;
      return (su * (la + x) + sv * y) >>> 1;
   endfunction

   task automatic model();
      int bet [N+1][NST];
      int al [NST];
      int an [NST];
      int mx, m1, m0, sm, d, e;
      for (int s = 0; s < NST; s++) bet[N][s] = (s == 0) ? 0 : NEG;   // R2
      for (int k = N - 1; k >= 0; k--) begin
         for (int s = 0; s < NST; s++) begin
            mx = -1000000;
            for (int u = 0; u < 2; u++) begin
               sm = gm(tl[k], tx[k], ty[k], u, parity(s, u)) + bet[k+1][nxt(s, u)];
               if (sm > mx) mx = sm;
            end
            bet[k][s] = mx;
         end
         mx = bet[k][0];
         for (int s = 1; s < NST; s++) if (bet[k][s] > mx) mx = bet[k][s];
         for (int s = 0; s < NST; s++) bet[k][s] -= mx;                // R4
      end
      for (int s = 0; s < NST; s++) al[s] = (s == 0) ? 0 : NEG;        // R3
      for (int k = 0; k < N; k++) begin
         m1 = -1000000; m0 = -1000000;
         for (int s = 0; s < NST; s++) an[s] = -1000000;
         for (int s = 0; s < NST; s++) begin
            for (int u = 0; u < 2; u++) begin
               sm = al[s] + gm(tl[k], tx[k], ty[k], u, parity(s, u));
               if (sm > an[nxt(s, u)]) an[nxt(s, u)] = sm;
               sm += bet[k+1][nxt(s, u)];
               if (u == 1) begin if (sm > m1) m1 = sm; end
               else if (sm > m0) m0 = sm;
            end
         end
         d = m1 - m0;
         e = d - tl[k] - tx[k];
         if (e > SAT) e = SAT;
         if (e < -SAT) e = -SAT;
         exp_e[k] = e;
         exp_h[k] = (d > 0) ? 1 : 0;
         mx = an[0];
         for (int s = 1; s < NST; s++) if (an[s] > mx) mx = an[s];
         for (int s = 0; s < NST; s++) al[s] = an[s] - mx;
      end
   endtask

   task automatic run_block(input bit extra);
      int nv = 0;
      int nd = 0;
      int idx;
      model();
      for (int k = 0; k < N; k++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(k);
         wr_sys = W'(tx[k]); wr_par = W'(ty[k]); wr_apri = W'(tl[k]);
      end
      @(negedge clk); wr_en = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 1; c <= 2 * N + 4; c++) begin
         @(negedge clk);
         if (ext_valid) begin
            idx = int'(ext_idx);
            chk(idx == nv, "R7 output order", idx, nv);
            chk(c == N + 1 + idx, "R7 output cycle", c, N + 1 + idx);
            chk(int'(ext_val) == exp_e[idx], "R1 R2 R3 R4 R5 extrinsic value", int'(ext_val), exp_e[idx]);
            chk(int'(hard_bit) == exp_h[idx], "R6 hard decision", int'(hard_bit), exp_h[idx]);
            if (use_ref) chk(int'(hard_bit) == ref_bit[idx], "R6 codeword bit", int'(hard_bit), ref_bit[idx]);
            nv++;
         end
         if (done) begin
            chk(c == 2 * N + 1, "R8 done cycle", c, 2 * N + 1);
            nd++;
         end
         if (extra) start = (c == 4);   // R9 pulse during the backward sweep
      end
      start = 1'b0;
      chk(nv == N, "R7 output count", nv, N);
      chk(nd == 1, "R8 R9 single done", nd, 1);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int s, a, u;
      repeat (4) @(negedge clk);
      chk(ext_valid == 1'b0, "R10 ext_valid in reset", int'(ext_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ext_valid == 1'b0, "R10 ext_valid after reset", int'(ext_valid), 0);
      chk(done == 1'b0, "R10 done after reset", int'(done), 0);

      // all-zero block: outputs shaped only by the start metrics
      for (int k = 0; k < N; k++) begin tx[k] = 0; ty[k] = 0; tl[k] = 0; end
      run_block(1'b0);

      // noiseless terminated codeword, zero a priori
      s = 0;
      for (int k = 0; k < N; k++) begin
         u = (k < N - 4) ? int'($urandom_range(0, 1)) : fbk(s, 0);
         a = fbk(s, u);
         ref_bit[k] = u;
         tx[k] = u ? 20 : -20;
         ty[k] = parity(s, u) ? 20 : -20;
         tl[k] = 0;
         s = nxt(s, u);
         if (a < 0) s = 0;
      end
      use_ref = 1'b1;
      run_block(1'b0);
      use_ref = 1'b0;

      // random soft inputs with a priori values
      for (int b = 0; b < 4; b++) begin
         for (int k = 0; k < N; k++) begin
            tx[k] = int'($urandom_range(0, 63)) - 32;
            ty[k] = int'($urandom_range(0, 63)) - 32;
            tl[k] = int'($urandom_range(0, 63)) - 32;
         end
         run_block(b == 1);
      end

      // extreme magnitudes for saturation
      for (int k = 0; k < N; k++) begin
         tx[k] = (k % 2) ? 31 : -32;
         ty[k] = (k % 3) ? -32 : 31;
         tl[k] = (k % 5) ? 31 : -32;
      end
      run_block(1'b1);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1'b1;
         nchk++; nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule